// File: doc/BRIEF.md
# DRAM Page Crossing Detector

This block sits beside an external memory interface and watches the stream of access addresses. For every access that decodes to bank 0, the only bank allowed to hold DRAM, it decides whether the access lands in a different DRAM page from the previous bank-0 access. It raises a flag when that happens, so that the memory side can close the old row and open a new one.

The page size is not fixed when the block is built. A small field from the memory control register selects it while the block runs. The flag is registered. It changes only on the clock edge that samples a bank-0 access. Otherwise it keeps the level it was last driven to: during idle cycles, and during accesses to other banks.

Top module: `dram_page_watch`

## Requirements
- R1: The page-size field `page_sel` (3 bits, value n = 0..7) selects a page of 2^(8+n) words. A page is identified by address bits [ADDR_W-1 : 8+n], so with n=0 addresses 0x0FF and 0x100 lie in different pages, and with n=7 addresses 0x0100 and 0x7FFF lie in the same page.
- R2: On the rising edge that samples a bank-0 access (`acc_valid`=1, `acc_bank`=0), `page_cross` becomes 0 if the access is in the same page as the previous bank-0 access, or 1 if it is in a different page. The new value is visible after that edge.
- R3: In a cycle with `acc_valid`=0, `page_cross` keeps its previous value.
- R4: An access with `acc_bank` not equal to 0 leaves `page_cross` unchanged. It also leaves the stored page unchanged, so a later bank-0 access is compared against the last bank-0 page.
- R5: The first bank-0 access after reset always sets `page_cross` to 1.
- R6: A bank-0 access made with a `page_sel` value different from the one in force at the previous bank-0 access sets `page_cross` to 1, even if its address is in the same page.
- R7: While `rst_n` is low, and right after reset, `page_cross` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | ADDR_W | Word address of the access |
| acc_bank | input | BANK_W | Decoded bank number of the access |
| page_sel | input | SIZE_W | Page-size field from the memory control register |
| page_cross | output | 1 | Registered page-crossed flag, holds between bank-0 accesses |

## Verification
The bench tests page boundaries at the smallest and largest page sizes. A design that masks the wrong number of address bits would either miss the 0x0FF to 0x100 crossing or report a false crossing inside a 32K-word page. It also places an access to another bank at a new page between two same-page bank-0 accesses. A design that stores the page for every bank would then report a false crossing. Further cases are the first access after reset, a page-size change at an unchanged address, and long idle stretches. These catch a missing valid flag, a missing size comparison, and a flag that wrongly returns to zero. Random traffic over a few nearby pages then mixes these cases.

// File: rtl/dram_page_watch.sv
module dram_page_watch #(
  parameter int ADDR_W     = 32,
  parameter int BANK_W     = 2,
  parameter int SIZE_W     = 3,
  parameter int BASE_SHIFT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [BANK_W-1:0] acc_bank,
  input  logic [SIZE_W-1:0] page_sel,
  output logic              page_cross
);

  localparam int MAX_SHIFT = BASE_SHIFT + (1 << SIZE_W) - 1;

  logic [ADDR_W-1:0] page_mask;
  logic [ADDR_W-1:0] cur_page;
  logic [ADDR_W-1:0] ref_page;
  logic [SIZE_W-1:0] ref_sel;
  logic              have_ref;
  logic              bank0_hit;
  logic              cross_now;

  assign bank0_hit = acc_valid && (acc_bank == '0);
  assign page_mask = {ADDR_W{1'b1}} << (BASE_SHIFT + int'(page_sel));
  assign cur_page  = acc_addr & page_mask;
  assign cross_now = !have_ref || (page_sel != ref_sel) || (cur_page != ref_page);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_cross <= 1'b0;
      ref_page   <= '0;
      ref_sel    <= '0;
      have_ref   <= 1'b0;
    end else if (bank0_hit) begin
      page_cross <= cross_now;
      ref_page   <= cur_page;
      ref_sel    <= page_sel;
      have_ref   <= 1'b1;
    end
  end

  initial begin
    assert_shift_fits_R1: assert (MAX_SHIFT < ADDR_W)
      else $error("page size exceeds address width");
  end

  assert_reset_low_R7: assert property (@(posedge clk) !rst_n |=> !page_cross);

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> $stable(page_cross));

  assert_other_bank_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_bank != '0) |=> $stable(page_cross));

  assert_first_cross_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bank0_hit && !have_ref) |=> page_cross);

  assert_size_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bank0_hit && have_ref && page_sel != ref_sel) |=> page_cross);

  assert_repeat_same_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bank0_hit && $past(rst_n) && $past(bank0_hit) && $stable(acc_addr) && $stable(page_sel))
      |=> !page_cross);

endmodule

// File: tb/dram_page_watch_test.sv
`timescale 1ns/1ps
module dram_page_watch_test;
  localparam int ADDR_W = 32;
  localparam int BANK_W = 2;
  localparam int SIZE_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0;
  logic [ADDR_W-1:0] acc_addr = '0;
  logic [BANK_W-1:0] acc_bank = '0;
  logic [SIZE_W-1:0] page_sel = '0;
  logic page_cross;

  int tests = 0;
  int fails = 0;

  logic m_have = 1'b0;
  logic [ADDR_W-1:0] m_page = '0;
  logic [SIZE_W-1:0] m_sel = '0;
  logic m_out = 1'b0;

  always #4 clk = ~clk;

  dram_page_watch #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .SIZE_W(SIZE_W), .BASE_SHIFT(8)) uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_bank(acc_bank), .page_sel(page_sel), .page_cross(page_cross));

  function automatic logic [ADDR_W-1:0] page_of(logic [ADDR_W-1:0] a, logic [SIZE_W-1:0] s);
    return a >> (8 + int'(s));
  endfunction

  task automatic check(string req, logic exp);
    tests++;
    if (page_cross !== exp) begin
      fails++;
      $display("FAIL %s: page_cross=%b expected=%b at %0t", req, page_cross, exp, $time);
    end
  endtask

  task automatic step(logic v, logic [ADDR_W-1:0] a, logic [BANK_W-1:0] b,
                      logic [SIZE_W-1:0] s, string req);
    acc_valid = v; acc_addr = a; acc_bank = b; page_sel = s;
    if (v && b == '0) begin
      m_out  = !m_have || (s != m_sel) || (page_of(a, s) != page_of(m_page, m_sel));
      m_page = a; m_sel = s; m_have = 1'b1;
    end
    @(negedge clk);
    check(req, m_out);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R7", 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7", 1'b0);

    step(1'b1, 32'h0000_0010, 2'd0, 3'd0, "R5");
    step(1'b1, 32'h0000_00FF, 2'd0, 3'd0, "R2");
    step(1'b1, 32'h0000_0100, 2'd0, 3'd0, "R1");
    repeat (4) step(1'b0, 32'hDEAD_BEEF, 2'd0, 3'd5, "R3");
    step(1'b1, 32'h0000_0120, 2'd0, 3'd0, "R2");
    step(1'b1, 32'h0009_0000, 2'd1, 3'd0, "R4");
    step(1'b1, 32'h0000_0130, 2'd0, 3'd0, "R4");
    step(1'b1, 32'h0000_0130, 2'd0, 3'd7, "R6");
    step(1'b1, 32'h0000_7FFF, 2'd0, 3'd7, "R1");
    step(1'b1, 32'h0000_8000, 2'd0, 3'd7, "R1");
    step(1'b1, 32'h0001_0000, 2'd3, 3'd7, "R4");
    step(1'b0, 32'h0000_0000, 2'd0, 3'd7, "R3");
    step(1'b1, 32'h0000_8001, 2'd0, 3'd7, "R2");
    step(1'b1, 32'h0000_8001, 2'd0, 3'd2, "R6");

    for (int i = 0; i < 3000; i++) begin
      int kind = int'($urandom % 10);
      logic [ADDR_W-1:0] a = (($urandom % 4) << 14) | ($urandom & 32'h3FFF);
      logic [SIZE_W-1:0] s = page_sel;
      if (kind < 3)       step(1'b0, a, 2'($urandom), s, "R3");
      else if (kind < 5)  step(1'b1, a, 2'd1 + 2'($urandom % 3), s, "R4");
      else if (kind == 5) step(1'b1, a, 2'd0, 3'($urandom), "R6");
      else                step(1'b1, a, 2'd0, s, "R2");
    end

    rst_n = 1'b0; acc_valid = 1'b0; m_have = 1'b0; m_out = 1'b0;
    @(negedge clk);
    check("R7", 1'b0);
    rst_n = 1'b1;
    step(1'b1, 32'h0000_8001, 2'd0, 3'd2, "R5");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule